// File: doc/BRIEF.md
# Single-Bus Add-From-Memory Control Sequencer

This block is the hardwired control unit of a processor built around one internal bus. A step counter moves through a fixed list of control steps. Each step drives a set of transfer strobes to the datapath: which register places its value on the bus, which register captures it, whether memory is read, and what the ALU does. The sequence covers the instruction fetch, with the program counter incremented through the ALU while the address goes out. It then runs one instruction that adds a memory operand to register R1.

Two steps wait for the memory. The counter holds there until the external memory-complete input is seen high at a clock edge. After the fetched word has been loaded into the instruction register, an idle decode step holds until the decoded instruction-class strobe is high. Only then does the instruction-specific part run. The closing step pulses an end-of-instruction strobe, and the next step is a new fetch. All strobes come straight from flip-flops.

Top module: `fetch_exec_seq`

## Requirements
- R1: While `rst` is sampled high, every output is low. The first clock edge with `rst` low presents the fetch step of R2.
- R2: Fetch step: `pc_out`, `mar_in`, `mem_rd`, `alu_use_const`, `alu_add` and `z_in` are high. All other outputs are low.
- R3: The step after the fetch step drives `z_out`, `pc_in` and `wait_mem`, and nothing else.
- R4: In a step with `wait_mem` high, the outputs hold unchanged across every edge where `mfc` is low. The first edge that samples `mfc` high leaves the step.
- R5: After the first memory wait, one step drives `mdr_out` and `ir_in`. It is followed by a decode step in which every output is low.
- R6: The decode step is left only on an edge that samples `ins` high. While `ins` is low at the edge, the outputs stay all low.
- R7: After the decode step, one step drives `ira_out`, `mar_in` and `mem_rd`. It is followed by a wait step that drives only `wait_mem` and behaves as in R4.
- R8: After the operand wait, three steps follow in order. The first drives `r1_out` and `y_in`. The second drives `mdr_out`, `alu_add` and `z_in`, with `alu_use_const` low so that Y is selected. The third drives `z_out`, `r1_in` and `end_instr`.
- R9: The step after the one that drives `end_instr` is the fetch step of R2.
- R10: At most one of the bus drivers `pc_out`, `z_out`, `mdr_out`, `ira_out`, `r1_out` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mfc | input | 1 | Memory operation complete, sampled at the clock edge |
| ins | input | 1 | Decoded strobe for the add-from-memory opcode |
| pc_out | output | 1 | Program counter drives the bus |
| pc_in | output | 1 | Program counter loads from the bus |
| mar_in | output | 1 | Memory address register loads from the bus |
| mem_rd | output | 1 | Memory read request |
| alu_use_const | output | 1 | ALU second operand is the increment constant (low: Y register) |
| alu_add | output | 1 | ALU performs addition |
| z_in | output | 1 | Z temporary loads the ALU result |
| z_out | output | 1 | Z temporary drives the bus |
| mdr_out | output | 1 | Memory data register drives the bus |
| ir_in | output | 1 | Instruction register loads from the bus |
| ira_out | output | 1 | Address field of the instruction register drives the bus |
| r1_out | output | 1 | Register R1 drives the bus |
| r1_in | output | 1 | Register R1 loads from the bus |
| y_in | output | 1 | ALU Y holding register loads from the bus |
| wait_mem | output | 1 | Sequencer is waiting on `mfc` |
| end_instr | output | 1 | Last step of the instruction |

## Verification
Every step has its own strobe pattern, so a wrong step value shows at the ports in the very next cycle. It appears as a strobe set that does not match the expected step. A counter that skips a wait shows as the wrong pattern one edge after an `mfc`-low sample. A lost `ins` gate shows as the operand step appearing while `ins` was low. The bench runs a step model driven only by `mfc` and `ins` and compares all sixteen strobes in every cycle, including random stall lengths and a reset in the middle of an instruction.

// File: rtl/fes_pkg.sv
package fes_pkg;

  localparam int NUM_STEPS = 9;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH  = STEP_W'(0),
    ST_PCWB   = STEP_W'(1),
    ST_IRLD   = STEP_W'(2),
    ST_DECODE = STEP_W'(3),
    ST_OPADDR = STEP_W'(4),
    ST_OPWAIT = STEP_W'(5),
    ST_LOADY  = STEP_W'(6),
    ST_SUM    = STEP_W'(7),
    ST_WRITE  = STEP_W'(8)
  } step_e;

  typedef struct packed {
    logic pc_out;
    logic pc_in;
    logic mar_in;
    logic mem_rd;
    logic alu_use_const;
    logic alu_add;
    logic z_in;
    logic z_out;
    logic mdr_out;
    logic ir_in;
    logic ira_out;
    logic r1_out;
    logic r1_in;
    logic y_in;
    logic wait_mem;
    logic end_instr;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/fes_step_ctr.sv
module fes_step_ctr
  import fes_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  mfc,
  input  logic  ins,
  output step_e step_nxt
);

  step_e step_q;

  // step_q is the step whose strobes are on the outputs; reset parks it on
  // the closing step so the first edge after release presents the fetch.
  always_comb begin
    step_nxt = step_q;
    unique case (step_q)
      ST_FETCH:  step_nxt = ST_PCWB;
      ST_PCWB:   step_nxt = mfc ? ST_IRLD : ST_PCWB;
      ST_IRLD:   step_nxt = ST_DECODE;
      ST_DECODE: step_nxt = ins ? ST_OPADDR : ST_DECODE;
      ST_OPADDR: step_nxt = ST_OPWAIT;
      ST_OPWAIT: step_nxt = mfc ? ST_LOADY : ST_OPWAIT;
      ST_LOADY:  step_nxt = ST_SUM;
      ST_SUM:    step_nxt = ST_WRITE;
      ST_WRITE:  step_nxt = ST_FETCH;
      default:   step_nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_WRITE;
    else     step_q <= step_nxt;
  end

endmodule

// File: rtl/fes_strobe_dec.sv
module fes_strobe_dec
  import fes_pkg::*;
(
  input  step_e step,
  output ctrl_t ctrl
);

  always_comb begin
    ctrl = CTRL_IDLE;
    unique case (step)
      ST_FETCH: begin
        ctrl.pc_out        = 1'b1;
        ctrl.mar_in        = 1'b1;
        ctrl.mem_rd        = 1'b1;
        ctrl.alu_use_const = 1'b1;
        ctrl.alu_add       = 1'b1;
        ctrl.z_in          = 1'b1;
      end
      ST_PCWB: begin
        ctrl.z_out    = 1'b1;
        ctrl.pc_in    = 1'b1;
        ctrl.wait_mem = 1'b1;
      end
      ST_IRLD: begin
        ctrl.mdr_out = 1'b1;
        ctrl.ir_in   = 1'b1;
      end
      ST_DECODE: ctrl = CTRL_IDLE;
      ST_OPADDR: begin
        ctrl.ira_out = 1'b1;
        ctrl.mar_in  = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      ST_OPWAIT: ctrl.wait_mem = 1'b1;
      ST_LOADY: begin
        ctrl.r1_out = 1'b1;
        ctrl.y_in   = 1'b1;
      end
      ST_SUM: begin
        ctrl.mdr_out = 1'b1;
        ctrl.alu_add = 1'b1;
        ctrl.z_in    = 1'b1;
      end
      ST_WRITE: begin
        ctrl.z_out     = 1'b1;
        ctrl.r1_in     = 1'b1;
        ctrl.end_instr = 1'b1;
      end
      default: ctrl = CTRL_IDLE;
    endcase
  end

endmodule

// File: rtl/fes_out_reg.sv
module fes_out_reg
  import fes_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl_d,
  output ctrl_t ctrl_q
);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_IDLE;
    else     ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
  import fes_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mfc,
  input  logic ins,
  output logic pc_out,
  output logic pc_in,
  output logic mar_in,
  output logic mem_rd,
  output logic alu_use_const,
  output logic alu_add,
  output logic z_in,
  output logic z_out,
  output logic mdr_out,
  output logic ir_in,
  output logic ira_out,
  output logic r1_out,
  output logic r1_in,
  output logic y_in,
  output logic wait_mem,
  output logic end_instr
);

  step_e step_nxt;
  ctrl_t ctrl_d;
  ctrl_t ctrl_q;

  fes_step_ctr u_ctr (
    .clk      (clk),
    .rst      (rst),
    .mfc      (mfc),
    .ins      (ins),
    .step_nxt (step_nxt)
  );

  // Decode the step being entered so the strobes land in flip-flops
  // on the same edge as the step itself.
  fes_strobe_dec u_dec (
    .step (step_nxt),
    .ctrl (ctrl_d)
  );

  fes_out_reg u_oreg (
    .clk    (clk),
    .rst    (rst),
    .ctrl_d (ctrl_d),
    .ctrl_q (ctrl_q)
  );

  assign pc_out        = ctrl_q.pc_out;
  assign pc_in         = ctrl_q.pc_in;
  assign mar_in        = ctrl_q.mar_in;
  assign mem_rd        = ctrl_q.mem_rd;
  assign alu_use_const = ctrl_q.alu_use_const;
  assign alu_add       = ctrl_q.alu_add;
  assign z_in          = ctrl_q.z_in;
  assign z_out         = ctrl_q.z_out;
  assign mdr_out       = ctrl_q.mdr_out;
  assign ir_in         = ctrl_q.ir_in;
  assign ira_out       = ctrl_q.ira_out;
  assign r1_out        = ctrl_q.r1_out;
  assign r1_in         = ctrl_q.r1_in;
  assign y_in          = ctrl_q.y_in;
  assign wait_mem      = ctrl_q.wait_mem;
  assign end_instr     = ctrl_q.end_instr;

endmodule

// File: rtl/fetch_exec_seq_chk.sv
module fetch_exec_seq_chk (
  input logic clk,
  input logic rst,
  input logic mfc,
  input logic pc_out,
  input logic pc_in,
  input logic mar_in,
  input logic mem_rd,
  input logic alu_use_const,
  input logic alu_add,
  input logic z_in,
  input logic z_out,
  input logic mdr_out,
  input logic ir_in,
  input logic ira_out,
  input logic r1_out,
  input logic r1_in,
  input logic y_in,
  input logic wait_mem,
  input logic end_instr
);

  logic [15:0] vec;
  assign vec = {pc_out, pc_in, mar_in, mem_rd, alu_use_const, alu_add, z_in,
                z_out, mdr_out, ir_in, ira_out, r1_out, r1_in, y_in,
                wait_mem, end_instr};

  a_r10_single_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_out, z_out, mdr_out, ira_out, r1_out}));

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (vec == 16'h0000));

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (wait_mem && !mfc) |=> (wait_mem && $stable(vec)));

  a_r4_leave_wait: assert property (@(posedge clk) disable iff (rst)
    (wait_mem && mfc) |=> !wait_mem);

  a_r3_pc_writeback: assert property (@(posedge clk) disable iff (rst)
    pc_out |=> (z_out && pc_in && wait_mem));

  a_r8_sum_after_y: assert property (@(posedge clk) disable iff (rst)
    y_in |=> (mdr_out && alu_add && z_in && !alu_use_const));

  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    end_instr |=> (pc_out && mar_in && mem_rd && alu_use_const && alu_add && z_in));

endmodule

bind fetch_exec_seq fetch_exec_seq_chk u_chk (
  .clk(clk), .rst(rst), .mfc(mfc),
  .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mem_rd(mem_rd),
  .alu_use_const(alu_use_const), .alu_add(alu_add), .z_in(z_in),
  .z_out(z_out), .mdr_out(mdr_out), .ir_in(ir_in), .ira_out(ira_out),
  .r1_out(r1_out), .r1_in(r1_in), .y_in(y_in), .wait_mem(wait_mem),
  .end_instr(end_instr)
);

// File: tb/fetch_exec_seq_test.sv
module fetch_exec_seq_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mfc = 1'b0;
  logic ins = 1'b0;
  logic pc_out, pc_in, mar_in, mem_rd, alu_use_const, alu_add, z_in, z_out;
  logic mdr_out, ir_in, ira_out, r1_out, r1_in, y_in, wait_mem, end_instr;

  int checks = 0;
  int errors = 0;
  int cur = 8;
  int prev = 8;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_exec_seq uut (
    .clk(clk), .rst(rst), .mfc(mfc), .ins(ins),
    .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mem_rd(mem_rd),
    .alu_use_const(alu_use_const), .alu_add(alu_add), .z_in(z_in),
    .z_out(z_out), .mdr_out(mdr_out), .ir_in(ir_in), .ira_out(ira_out),
    .r1_out(r1_out), .r1_in(r1_in), .y_in(y_in), .wait_mem(wait_mem),
    .end_instr(end_instr)
  );

  // Bit order: pc_out pc_in mar_in mem_rd alu_use_const alu_add z_in z_out
  //            mdr_out ir_in ira_out r1_out r1_in y_in wait_mem end_instr
  function automatic logic [15:0] golden(input int s);
    case (s)
      0: golden = 16'hBE00;  // R2 fetch
      1: golden = 16'h4102;  // R3 write back PC, wait
      2: golden = 16'h00C0;  // R5 MDR to IR
      3: golden = 16'h0000;  // R6 decode idle
      4: golden = 16'h3020;  // R7 operand address
      5: golden = 16'h0002;  // R7 operand wait
      6: golden = 16'h0014;  // R8 R1 to Y
      7: golden = 16'h0680;  // R8 sum
      default: golden = 16'h0109;  // R8 write R1, end
    endcase
  endfunction

  function automatic int next_step(input int s, input logic m, input logic i);
    case (s)
      1: next_step = m ? 2 : 1;
      3: next_step = i ? 4 : 3;
      5: next_step = m ? 6 : 5;
      8: next_step = 0;
      default: next_step = s + 1;
    endcase
  endfunction

  function automatic string req_tag(input int s, input int p);
    if ((s == 1 || s == 5) && s == p) req_tag = "R4";
    else case (s)
      0: req_tag = (p == 8) ? "R9" : "R2";
      1: req_tag = "R3";
      2: req_tag = "R5";
      3: req_tag = "R6";
      4, 5: req_tag = "R7";
      default: req_tag = "R8";
    endcase
  endfunction

  task automatic cyc(input logic m, input logic i, input logic r);
    logic [15:0] got, exp;
    string tag;
    @(negedge clk);
    mfc = m; ins = i; rst = r;
    @(posedge clk);
    prev = cur;
    if (r) cur = 8;
    else   cur = next_step(cur, m, i);
    #1;
    got = {pc_out, pc_in, mar_in, mem_rd, alu_use_const, alu_add, z_in,
           z_out, mdr_out, ir_in, ira_out, r1_out, r1_in, y_in,
           wait_mem, end_instr};
    if (r) begin
      exp = 16'h0000;
      tag = "R1";
    end else begin
      exp = golden(cur);
      tag = (prev == 8 && cur == 0 && checks < 8) ? "R1" : req_tag(cur, prev);
    end
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s step %0d strobes got %h expected %h", tag, cur, got, exp);
    end
    checks++;
    if ($countones({pc_out, z_out, mdr_out, ira_out, r1_out}) > 1) begin
      errors++;
      $display("FAIL R10 bus drivers got %b expected at most one high",
               {pc_out, z_out, mdr_out, ira_out, r1_out});
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    // R1: reset held
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 1'b1);
    // R4/R5/R7/R8/R9: no stalls, opcode strobe always high
    for (int k = 0; k < 30; k++) cyc(1'b1, 1'b1, 1'b0);
    // R4: long stalls in both waits
    for (int k = 0; k < 80; k++) cyc(k % 16 == 15, 1'b1, 1'b0);
    // R6: opcode strobe low for long stretches
    for (int k = 0; k < 80; k++) cyc(1'b1, k % 12 == 11, 1'b0);
    // R1: reset in the middle of an instruction
    for (int k = 0; k < 5; k++) cyc(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 2; k++) cyc(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b0);
    // random stalls and decode gating
    for (int k = 0; k < 2000; k++)
      cyc(($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 400) == 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      finish_run();
    end
  end

endmodule